// File: doc/BRIEF.md
# Bit-Serial Save EEPROM Slave

This block behaves as a small serial EEPROM that sits behind a cartridge bus. The host moves one bit per bus access: every write strobe delivers the bit on `wr_bit`, and every read strobe yields one bit on `rd_bit`. A transaction opens with a two-bit command. A block address follows, and its width depends on the device size. A write then carries 64 data bits. The storage is organised as 64-bit blocks held in a local RAM.

A read is answered with four zero bits and then the 64 stored bits, most significant first. After a write has been committed, the block stays busy. The host polls during this time: it sees zeros until a fixed poll count, and the last poll of that count returns a one. Storage depth is set by a parameter. The address decoded on the serial line is 6 bits or 14 bits, chosen by the static `large_dev` input. Only the low `STORE_AW` address bits select a stored block.

Top module: `eeprom_serial_slave`

## Requirements
- R1: A synchronous active-high `rst` returns the block to idle and clears its bit counter, shift registers and `rd_bit`. The stored blocks are kept.
- R2: In idle, two write strobes form a command, first bit as the MSB. `2'b10` starts a write and `2'b11` starts a read. `2'b00` or `2'b01` leaves the block idle, and the next strobe begins a new command.
- R3: The address is shifted in MSB first. It is 6 bits when `large_dev`=0 and 14 bits when `large_dev`=1. The stored block is selected by the low `STORE_AW` (default 6) bits of the address.
- R4: For a read, one terminator bit follows the address, and its value is ignored. The first 4 read strobes after the terminator return 0.
- R5: The next 64 read strobes return the addressed block, MSB first. After the 68th read the block is idle again.
- R6: For a write, 64 data bits follow the address, MSB first. The next write strobe commits them to the addressed block, and its bit value is ignored.
- R7: After a commit, read strobes return 0 up to the 1000th, which returns 1. The block is then idle.
- R8: A read strobe in idle, command, address or write-data phase returns 0 and changes no transaction state. A write strobe during a read response or the busy period is ignored.
- R9: If `rd_stb` and `wr_stb` are high in the same cycle, the read is served and the write bit is dropped.
- R10: `rd_bit` is registered. It takes the value of a read strobe on the clock edge that samples the strobe, and holds while no read strobe arrives.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| large_dev | input | 1 | Static size select: 0 for a 6-bit address, 1 for a 14-bit address |
| wr_stb | input | 1 | One-cycle write access strobe |
| wr_bit | input | 1 | Serial bit carried by a write strobe |
| rd_stb | input | 1 | One-cycle read access strobe |
| rd_bit | output | 1 | Serial bit returned by the latest read strobe |

## Verification
The embedded properties check the following on every cycle:
- the reset outcome;
- the zero dummy bits;
- the return to idle at the end of a response;
- the exact poll on which the busy period ends, and the zeros before it;
- that read strobes outside the response and busy phases have no effect, and that write strobes during the busy period are ignored;
- that `rd_bit` holds between reads.

The directed scenarios show the following:
- a block written MSB first comes back intact;
- rejected commands are discarded;
- both address widths work, and the large address is truncated to the stored index;
- the terminator value is ignored;
- write strobes dropped during a response or on a collision with a read leave the data intact;
- a reset in the middle of a transaction aborts it cleanly.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_RD_ADDR,
        S_WR_ADDR,
        S_WR_DATA,
        S_RD_RESP,
        S_BUSY
    } eep_state_e;

    localparam logic [1:0] CMD_WRITE = 2'b10;
    localparam logic [1:0] CMD_READ  = 2'b11;

endpackage

// File: rtl/eep_block_ram.sv
module eep_block_ram #(
    parameter int AW = 6,
    parameter int DW = 64
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[addr] <= wdata;
        end
    end

    assign rdata = mem_q[addr];

endmodule

// File: rtl/eep_ctrl.sv
module eep_ctrl
    import eep_pkg::*;
#(
    parameter int DATA_W     = 64,
    parameter int SMALL_AW   = 6,
    parameter int LARGE_AW   = 14,
    parameter int STORE_AW   = 6,
    parameter int DUMMY_BITS = 4,
    parameter int BUSY_POLLS = 1000
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                large_dev,
    input  logic                wr_stb,
    input  logic                wr_bit,
    input  logic                rd_stb,
    output logic                rd_bit,
    output logic                ram_we,
    output logic [STORE_AW-1:0] ram_addr,
    output logic [DATA_W-1:0]   ram_wdata,
    input  logic [DATA_W-1:0]   ram_rdata
);
    localparam int RESP_LEN = DUMMY_BITS + DATA_W;
    localparam int MAX_A    = (BUSY_POLLS > RESP_LEN) ? BUSY_POLLS : RESP_LEN;
    localparam int MAX_B    = (MAX_A > LARGE_AW + 1) ? MAX_A : LARGE_AW + 1;
    localparam int CNT_W    = $clog2(MAX_B + 1);
    localparam int SH_W     = LARGE_AW + 1;

    localparam logic [CNT_W-1:0] C_ONE     = CNT_W'(1);
    localparam logic [CNT_W-1:0] C_TWO     = CNT_W'(2);
    localparam logic [CNT_W-1:0] C_DUMMY   = CNT_W'(DUMMY_BITS);
    localparam logic [CNT_W-1:0] C_RESP    = CNT_W'(RESP_LEN);
    localparam logic [CNT_W-1:0] C_DATA    = CNT_W'(DATA_W);
    localparam logic [CNT_W-1:0] C_BUSY    = CNT_W'(BUSY_POLLS);
    localparam logic [CNT_W-1:0] C_SM_LAST = CNT_W'(SMALL_AW + 1);
    localparam logic [CNT_W-1:0] C_LG_LAST = CNT_W'(LARGE_AW + 1);

    typedef struct packed {
        eep_state_e          st;
        logic [CNT_W-1:0]    cnt;
        logic [SH_W-1:0]     sh;
        logic [STORE_AW-1:0] idx;
        logic [DATA_W-1:0]   data;
        logic                rd;
    } regs_t;

    regs_t r_d, r_q;

    logic [CNT_W-1:0]    cnt_inc;
    logic [CNT_W-1:0]    addr_last;
    logic [SH_W-1:0]     shifted;
    logic [LARGE_AW-1:0] full_addr;
    logic [STORE_AW-1:0] new_idx;

    always_comb begin
        cnt_inc   = r_q.cnt + C_ONE;
        addr_last = large_dev ? C_LG_LAST : C_SM_LAST;
        shifted   = {r_q.sh[SH_W-2:0], wr_bit};
        full_addr = large_dev ? shifted[LARGE_AW:1]
                              : LARGE_AW'(shifted[SMALL_AW:1]);
        new_idx   = full_addr[STORE_AW-1:0];

        r_d       = r_q;
        ram_we    = 1'b0;
        ram_addr  = r_q.idx;
        ram_wdata = r_q.data;

        if (rd_stb) begin
            unique case (r_q.st)
                S_RD_RESP: begin
                    r_d.cnt = cnt_inc;
                    if (cnt_inc <= C_DUMMY) begin
                        r_d.rd = 1'b0;
                    end else begin
                        r_d.rd   = r_q.data[DATA_W-1];
                        r_d.data = {r_q.data[DATA_W-2:0], 1'b0};
                    end
                    if (cnt_inc == C_RESP) begin
                        r_d.st  = S_IDLE;
                        r_d.cnt = '0;
                    end
                end
                S_BUSY: begin
                    if (cnt_inc == C_BUSY) begin
                        r_d.st  = S_IDLE;
                        r_d.cnt = '0;
                        r_d.rd  = 1'b1;
                    end else begin
                        r_d.cnt = cnt_inc;
                        r_d.rd  = 1'b0;
                    end
                end
                default: r_d.rd = 1'b0;
            endcase
        end else if (wr_stb) begin
            unique case (r_q.st)
                S_IDLE: begin
                    r_d.sh  = shifted;
                    r_d.cnt = cnt_inc;
                    if (cnt_inc == C_TWO) begin
                        r_d.cnt = '0;
                        r_d.sh  = '0;
                        if (shifted[1:0] == CMD_WRITE) begin
                            r_d.st = S_WR_ADDR;
                        end else if (shifted[1:0] == CMD_READ) begin
                            r_d.st = S_RD_ADDR;
                        end
                    end
                end
                S_RD_ADDR: begin
                    r_d.sh  = shifted;
                    r_d.cnt = cnt_inc;
                    if (cnt_inc == addr_last) begin
                        ram_addr = new_idx;
                        r_d.idx  = new_idx;
                        r_d.data = ram_rdata;
                        r_d.cnt  = '0;
                        r_d.sh   = '0;
                        r_d.st   = S_RD_RESP;
                    end
                end
                S_WR_ADDR: begin
                    r_d.sh  = shifted;
                    r_d.cnt = cnt_inc;
                    if (cnt_inc == addr_last) begin
                        r_d.idx  = new_idx;
                        r_d.data = {{(DATA_W-1){1'b0}}, wr_bit};
                        r_d.cnt  = C_ONE;
                        r_d.sh   = '0;
                        r_d.st   = S_WR_DATA;
                    end
                end
                S_WR_DATA: begin
                    if (r_q.cnt == C_DATA) begin
                        ram_we  = 1'b1;
                        r_d.st  = S_BUSY;
                        r_d.cnt = '0;
                    end else begin
                        r_d.data = {r_q.data[DATA_W-2:0], wr_bit};
                        r_d.cnt  = cnt_inc;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '{st: S_IDLE, cnt: '0, sh: '0, idx: '0, data: '0, rd: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign rd_bit = r_q.rd;

    eep_state_e       st_q;
    logic [CNT_W-1:0] cnt_q;
    assign st_q  = r_q.st;
    assign cnt_q = r_q.cnt;

    p_reset_idle_r1: assert property (@(posedge clk)
        rst |=> (st_q == S_IDLE && cnt_q == '0 && !rd_bit));

    p_dummy_zero_r4: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && st_q == S_RD_RESP && cnt_q < C_DUMMY) |=> !rd_bit);

    p_resp_end_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && st_q == S_RD_RESP && cnt_q == C_RESP - C_ONE) |=> st_q == S_IDLE);

    p_commit_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !rd_stb && st_q == S_WR_DATA && cnt_q == C_DATA) |=> st_q == S_BUSY);

    p_busy_done_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && st_q == S_BUSY && cnt_q == C_BUSY - C_ONE)
            |=> (st_q == S_IDLE && rd_bit));

    p_busy_wait_r7: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && st_q == S_BUSY && cnt_q != C_BUSY - C_ONE)
            |=> (st_q == S_BUSY && !rd_bit));

    p_quiet_read_r8: assert property (@(posedge clk) disable iff (rst)
        (rd_stb && st_q != S_RD_RESP && st_q != S_BUSY)
            |=> (!rd_bit && $stable(st_q) && $stable(cnt_q)));

    p_busy_ignores_wr_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && !rd_stb && st_q == S_BUSY) |=> (st_q == S_BUSY && $stable(cnt_q)));

    p_rd_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !rd_stb |=> $stable(rd_bit));

endmodule

// File: rtl/eeprom_serial_slave.sv
module eeprom_serial_slave #(
    parameter int DATA_W     = 64,
    parameter int SMALL_AW   = 6,
    parameter int LARGE_AW   = 14,
    parameter int STORE_AW   = 6,
    parameter int DUMMY_BITS = 4,
    parameter int BUSY_POLLS = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic large_dev,
    input  logic wr_stb,
    input  logic wr_bit,
    input  logic rd_stb,
    output logic rd_bit
);
    logic                ram_we;
    logic [STORE_AW-1:0] ram_addr;
    logic [DATA_W-1:0]   ram_wdata;
    logic [DATA_W-1:0]   ram_rdata;

    eep_ctrl #(
        .DATA_W     (DATA_W),
        .SMALL_AW   (SMALL_AW),
        .LARGE_AW   (LARGE_AW),
        .STORE_AW   (STORE_AW),
        .DUMMY_BITS (DUMMY_BITS),
        .BUSY_POLLS (BUSY_POLLS)
    ) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .large_dev (large_dev),
        .wr_stb    (wr_stb),
        .wr_bit    (wr_bit),
        .rd_stb    (rd_stb),
        .rd_bit    (rd_bit),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .ram_rdata (ram_rdata)
    );

    eep_block_ram #(
        .AW (STORE_AW),
        .DW (DATA_W)
    ) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  (ram_addr),
        .wdata (ram_wdata),
        .rdata (ram_rdata)
    );

endmodule

// File: tb/eeprom_serial_slave_bench.sv
`timescale 1ns/1ps
module eeprom_serial_slave_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic large_dev = 1'b0;
    logic wr_stb = 1'b0;
    logic wr_bit = 1'b0;
    logic rd_stb = 1'b0;
    logic rd_bit;

    int checks = 0;
    int errors = 0;

    localparam logic [63:0] D0 = 64'hA5C3_0F1E_8877_0123;
    localparam logic [63:0] D1 = 64'h8000_0000_0000_0001;
    localparam logic [63:0] D2 = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] D3 = 64'hFEDC_BA98_7654_3210;

    always #2 clk = ~clk;

    eeprom_serial_slave u_eeprom_serial_slave (
        .clk       (clk),
        .rst       (rst),
        .large_dev (large_dev),
        .wr_stb    (wr_stb),
        .wr_bit    (wr_bit),
        .rd_stb    (rd_stb),
        .rd_bit    (rd_bit)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wbit(input logic b);
        @(negedge clk);
        wr_stb = 1'b1;
        wr_bit = b;
        @(negedge clk);
        wr_stb = 1'b0;
        wr_bit = 1'b0;
    endtask

    task automatic rbit(output logic v);
        @(negedge clk);
        rd_stb = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        v = rd_bit;
    endtask

    task automatic send_bits(input logic [63:0] val, input int n);
        for (int i = n - 1; i >= 0; i--) wbit(val[i]);
    endtask

    task automatic start(input logic [1:0] cmd, input logic [13:0] addr);
        send_bits(64'(cmd), 2);
        send_bits(64'(addr), large_dev ? 14 : 6);
    endtask

    task automatic write_block(input logic [13:0] addr, input logic [63:0] d);
        start(2'b10, addr);
        send_bits(d, 64);
        wbit(1'b1);
    endtask

    task automatic poll_busy(input string req);
        logic v;
        int early = 0;
        for (int i = 1; i < 1000; i++) begin
            rbit(v);
            if (v) early++;
        end
        chk({req, " busy polls before last are zero"}, 64'(early), 64'd0);
        rbit(v);
        chk({req, " 1000th poll returns 1"}, 64'(v), 64'd1);
    endtask

    task automatic read_resp(input string req, input logic [63:0] exp, input int dummies_done);
        logic v;
        int ones = 0;
        logic [63:0] got = '0;
        for (int i = dummies_done; i < 4; i++) begin
            rbit(v);
            if (v) ones++;
        end
        chk({req, " R4 dummy bits zero"}, 64'(ones), 64'd0);
        for (int i = 0; i < 64; i++) begin
            rbit(v);
            got = {got[62:0], v};
        end
        chk({req, " R5 block data"}, got, exp);
        rbit(v);
        chk({req, " R5 idle after 68 reads"}, 64'(v), 64'd0);
    endtask

    task automatic read_block(input string req, input logic [13:0] addr,
                              input logic term, input logic [63:0] exp);
        start(2'b11, addr);
        wbit(term);
        read_resp(req, exp, 0);
    endtask

    task automatic t_reset();
        logic v;
        do_reset();
        chk("R1 rd_bit after reset", 64'(rd_bit), 64'd0);
        rbit(v);
        chk("R8 read in idle returns 0", 64'(v), 64'd0);
    endtask

    task automatic t_write_small();
        logic v;
        start(2'b10, 14'd5);
        rbit(v);
        chk("R8 read in write-data phase", 64'(v), 64'd0);
        send_bits(D0, 64);
        wbit(1'b0);
        poll_busy("R7 small write");
        repeat (4) @(negedge clk);
        chk("R10 rd_bit held without strobe", 64'(rd_bit), 64'd1);
        rbit(v);
        chk("R7 idle after busy", 64'(v), 64'd0);
        read_block("R3 R6 small addr 5", 14'd5, 1'b0, D0);
    endtask

    task automatic t_addr_phase_read();
        logic v;
        send_bits(64'(2'b10), 2);
        send_bits(64'd9 >> 3, 3);
        rbit(v);
        chk("R8 read in address phase", 64'(v), 64'd0);
        send_bits(64'd9, 3);
        send_bits(D1, 64);
        wbit(1'b0);
        poll_busy("R6 addr 9");
    endtask

    task automatic t_bad_cmd();
        send_bits(64'(2'b01), 2);
        send_bits(64'(2'b00), 2);
        write_block(14'd20, D2);
        poll_busy("R2 after rejected cmds");
        read_block("R2 rejected cmds then write", 14'd20, 1'b1, D2);
        read_block("R4 terminator 1 addr 9", 14'd9, 1'b1, D1);
    endtask

    task automatic t_write_during_resp();
        logic v;
        start(2'b11, 14'd9);
        wbit(1'b0);
        rbit(v);
        rbit(v);
        wbit(1'b1);
        wbit(1'b0);
        wbit(1'b1);
        read_resp("R8 writes ignored in response", D1, 2);
    endtask

    task automatic t_write_during_busy();
        logic v;
        int early = 0;
        write_block(14'd12, D3);
        for (int i = 1; i <= 500; i++) begin
            rbit(v);
            if (v) early++;
        end
        send_bits(64'h7, 3);
        for (int i = 501; i < 1000; i++) begin
            rbit(v);
            if (v) early++;
        end
        chk("R8 writes ignored in busy, early ones", 64'(early), 64'd0);
        rbit(v);
        chk("R8 R7 busy count unaffected by writes", 64'(v), 64'd1);
        read_block("R6 addr 12", 14'd12, 1'b0, D3);
    endtask

    task automatic t_priority();
        logic v;
        @(negedge clk);
        rd_stb = 1'b1;
        wr_stb = 1'b1;
        wr_bit = 1'b1;
        @(negedge clk);
        rd_stb = 1'b0;
        wr_stb = 1'b0;
        wr_bit = 1'b0;
        v = rd_bit;
        chk("R9 collided read returns 0", 64'(v), 64'd0);
        read_block("R9 write bit dropped on collision", 14'd12, 1'b1, D3);
    endtask

    task automatic t_large();
        do_reset();
        large_dev = 1'b1;
        @(negedge clk);
        write_block(14'h2A07, D2);
        poll_busy("R3 large write");
        read_block("R3 large addr truncated", 14'h0007, 1'b0, D2);
        read_block("R3 large mode keeps addr 5", 14'h0005, 1'b1, D0);
    endtask

    task automatic t_reset_mid();
        logic v;
        start(2'b11, 14'd9);
        wbit(1'b0);
        for (int i = 0; i < 10; i++) rbit(v);
        do_reset();
        chk("R1 rd_bit cleared mid-read", 64'(rd_bit), 64'd0);
        rbit(v);
        chk("R1 idle after mid-read reset", 64'(v), 64'd0);
        read_block("R1 fresh read after reset", 14'd9, 1'b0, D1);
    endtask

    initial begin
        t_reset();
        t_write_small();
        t_addr_phase_read();
        t_bad_cmd();
        t_write_during_resp();
        t_write_during_busy();
        t_priority();
        t_reset_mid();
        t_large();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule